// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block keeps the atomic reservation of a single requester on one data cache line. A load-linked completion places the reservation on the line it touched. A later store-conditional completion checks whether the reservation is still held on its own line and reports pass or fail. Ordinary writes and coherence invalidations can clear the reservation, and so does every store-conditional. The cache array, the coherence protocol and arbitration between requesters are outside the block.

All three kinds of completion share one event port, so at most one of them arrives per cycle. The event carries a 2-bit kind code and a byte address. A separate invalidate port with its own line address can fire in any cycle, including the cycle of an event. Addresses are compared at line granularity: the low `OFFS_W` bits are ignored. The pass/fail verdict is registered and appears one cycle after the store-conditional.

Top module: `llsc_monitor`

## Requirements
- R1: After reset no reservation is held, `sc_valid_o` is 0 and `sc_ok_o` is 0, so a store-conditional issued first fails.
- R2: A load-linked (`op_kind_i` = 2'b01) always sets the reservation on the line of `op_addr_i`.
- R3: A store-conditional (`op_kind_i` = 2'b10) passes (`sc_ok_o` = 1) only when the reservation is held on its own line, and fails (`sc_ok_o` = 0) otherwise.
- R4: Every store-conditional clears the reservation, whether it passed or failed.
- R5: An ordinary write (`op_kind_i` = 2'b11) to the reserved line clears the reservation; a write to any other line leaves it in place.
- R6: `sc_valid_o` is 1 for exactly one cycle, the cycle after each store-conditional, and `sc_ok_o` is 0 whenever `sc_valid_o` is 0; code 2'b00 is idle and has no effect on the reservation.
- R7: An invalidate (`inv_valid_i` = 1) on the reserved line clears the reservation; an invalidate on any other line has no effect.
- R8: When an invalidate and an event name the same line in one cycle, the invalidate wins: a load-linked leaves no reservation and a store-conditional fails.
- R9: Two addresses that differ only in their low `OFFS_W` bits name the same line for every comparison.
- R10: Only one reservation exists; a load-linked to a new line replaces the earlier one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_kind_i | input | 2 | Completion kind: 00 idle, 01 load-linked, 10 store-conditional, 11 write |
| op_addr_i | input | ADDR_W | Byte address of the completing access |
| inv_valid_i | input | 1 | Coherence permission lost for a line |
| inv_addr_i | input | ADDR_W | Byte address in the line that lost permission |
| sc_valid_o | output | 1 | Store-conditional verdict is valid this cycle |
| sc_ok_o | output | 1 | Store-conditional passed |

## Verification
The invalidate port can fire in the same cycle as a load-linked or a store-conditional, and this is where the ordering matters. The bench drives both ports in one cycle, once on the same line and once on different lines, for each of the two event kinds. It then judges the outcome either from the verdict of that same store-conditional or from a following store-conditional to the load-linked's line. With a matching line, the invalidate must leave no reservation and force a fail. With a different line, the event must behave as if no invalidate were present.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_LL   = 2'b01,
    OP_SC   = 2'b10,
    OP_WR   = 2'b11
  } op_kind_e;
endpackage

// File: rtl/llsc_line_tag.sv
module llsc_line_tag #(
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 6,
  localparam int TAG_W = ADDR_W - OFFS_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [TAG_W-1:0]  tag_o
);
  if (OFFS_W == 0) begin : g_no_offs
    assign tag_o = addr_i;
  end else begin : g_offs
    logic [OFFS_W-1:0] unused_offs;
    assign unused_offs = addr_i[OFFS_W-1:0];
    assign tag_o       = addr_i[ADDR_W-1:OFFS_W];
  end
endmodule

// File: rtl/llsc_resv_next.sv
module llsc_resv_next
  import llsc_pkg::*;
#(
  parameter int TAG_W = 26
) (
  input  op_kind_e         kind_i,
  input  logic [TAG_W-1:0] op_tag_i,
  input  logic             inv_i,
  input  logic [TAG_W-1:0] inv_tag_i,
  input  logic             cur_valid_i,
  input  logic [TAG_W-1:0] cur_tag_i,
  output logic             nxt_valid_o,
  output logic [TAG_W-1:0] nxt_tag_o,
  output logic             sc_fire_o,
  output logic             sc_pass_o
);
  logic op_hit, inv_hit_cur;

  assign op_hit      = cur_valid_i && (op_tag_i == cur_tag_i);
  assign inv_hit_cur = inv_i && (inv_tag_i == cur_tag_i);

  always_comb begin
    nxt_valid_o = cur_valid_i;
    nxt_tag_o   = cur_tag_i;
    unique case (kind_i)
      OP_LL: begin
        nxt_valid_o = 1'b1;
        nxt_tag_o   = op_tag_i;
      end
      OP_SC: nxt_valid_o = 1'b0;
      OP_WR: if (op_hit) nxt_valid_o = 1'b0;
      default: ;
    endcase
    // invalidate applies after the event, so it also kills a fresh LL
    if (inv_i && (inv_tag_i == nxt_tag_o)) nxt_valid_o = 1'b0;
  end

  assign sc_fire_o = (kind_i == OP_SC);
  assign sc_pass_o = sc_fire_o && op_hit && !inv_hit_cur;
endmodule

// File: rtl/llsc_sc_resp.sv
module llsc_sc_resp (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic pass_i,
  output logic valid_o,
  output logic ok_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      ok_o    <= 1'b0;
    end else begin
      valid_o <= fire_i;
      ok_o    <= fire_i && pass_i;
    end
  end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 6,
  localparam int TAG_W = ADDR_W - OFFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        op_kind_i,
  input  logic [ADDR_W-1:0] op_addr_i,
  input  logic              inv_valid_i,
  input  logic [ADDR_W-1:0] inv_addr_i,
  output logic              sc_valid_o,
  output logic              sc_ok_o
);
  logic [TAG_W-1:0] op_tag, inv_tag;
  logic             resv_valid_q, resv_valid_d;
  logic [TAG_W-1:0] resv_tag_q, resv_tag_d;
  logic             sc_fire, sc_pass;

  llsc_line_tag #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_op_tag (
    .addr_i(op_addr_i), .tag_o(op_tag)
  );
  llsc_line_tag #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_inv_tag (
    .addr_i(inv_addr_i), .tag_o(inv_tag)
  );

  llsc_resv_next #(.TAG_W(TAG_W)) u_next (
    .kind_i      (op_kind_e'(op_kind_i)),
    .op_tag_i    (op_tag),
    .inv_i       (inv_valid_i),
    .inv_tag_i   (inv_tag),
    .cur_valid_i (resv_valid_q),
    .cur_tag_i   (resv_tag_q),
    .nxt_valid_o (resv_valid_d),
    .nxt_tag_o   (resv_tag_d),
    .sc_fire_o   (sc_fire),
    .sc_pass_o   (sc_pass)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resv_valid_q <= 1'b0;
      resv_tag_q   <= '0;
    end else begin
      resv_valid_q <= resv_valid_d;
      resv_tag_q   <= resv_tag_d;
    end
  end

  llsc_sc_resp u_resp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (sc_fire),
    .pass_i  (sc_pass),
    .valid_o (sc_valid_o),
    .ok_o    (sc_ok_o)
  );
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 6,
  localparam int TAG_W = ADDR_W - OFFS_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        op_kind_i,
  input logic [ADDR_W-1:0] op_addr_i,
  input logic              inv_valid_i,
  input logic [ADDR_W-1:0] inv_addr_i,
  input logic              sc_valid_o,
  input logic              sc_ok_o,
  input logic              resv_valid_q,
  input logic [TAG_W-1:0]  resv_tag_q
);
  logic is_ll, is_sc, same_line;
  assign is_ll     = (op_kind_i == 2'b01);
  assign is_sc     = (op_kind_i == 2'b10);
  assign same_line = (op_addr_i[ADDR_W-1:OFFS_W] == inv_addr_i[ADDR_W-1:OFFS_W]);

  AST_LL_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ll && !inv_valid_i |=> resv_valid_q && resv_tag_q == $past(op_addr_i[ADDR_W-1:OFFS_W])); // R2

  AST_SC_NO_RESV_FAILS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_sc && !resv_valid_q |=> sc_valid_o && !sc_ok_o); // R3

  AST_SC_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_sc |=> !resv_valid_q); // R4

  AST_VERDICT_AFTER_SC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_valid_o |-> $past(is_sc)); // R6

  AST_OK_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_ok_o |-> sc_valid_o); // R6

  AST_INV_BEATS_LL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ll && inv_valid_i && same_line |=> !resv_valid_q); // R8

  AST_INV_BEATS_SC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_sc && inv_valid_i && same_line |=> !sc_ok_o); // R8
endmodule

bind llsc_monitor llsc_monitor_chk #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .op_kind_i    (op_kind_i),
  .op_addr_i    (op_addr_i),
  .inv_valid_i  (inv_valid_i),
  .inv_addr_i   (inv_addr_i),
  .sc_valid_o   (sc_valid_o),
  .sc_ok_o      (sc_ok_o),
  .resv_valid_q (resv_valid_q),
  .resv_tag_q   (resv_tag_q)
);

// File: tb/tb_llsc_monitor.sv
module tb_llsc_monitor;
  localparam int ADDR_W   = 32;
  localparam int OFFS_W   = 6;
  localparam int CLK_PER  = 10;

  localparam logic [1:0] K_IDLE = 2'b00;
  localparam logic [1:0] K_LL   = 2'b01;
  localparam logic [1:0] K_SC   = 2'b10;
  localparam logic [1:0] K_WR   = 2'b11;

  localparam logic [ADDR_W-1:0] LA  = 32'h0000_1000;
  localparam logic [ADDR_W-1:0] LA2 = 32'h0000_1024;
  localparam logic [ADDR_W-1:0] LB  = 32'h0000_2000;

  typedef struct {
    logic  ok;
    string tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        op_kind = K_IDLE;
  logic [ADDR_W-1:0] op_addr = '0;
  logic              inv_valid = 1'b0;
  logic [ADDR_W-1:0] inv_addr = '0;
  logic              sc_valid, sc_ok;

  int   n_checks = 0;
  int   n_fails  = 0;
  bit   done     = 1'b0;
  exp_t expq[$];

  // bench-side reservation model
  logic              m_valid = 1'b0;
  logic [ADDR_W-1:0] m_line  = '0;

  always #(CLK_PER/2) clk = ~clk;

  llsc_monitor #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .op_kind_i(op_kind), .op_addr_i(op_addr),
    .inv_valid_i(inv_valid), .inv_addr_i(inv_addr),
    .sc_valid_o(sc_valid), .sc_ok_o(sc_ok)
  );

  function automatic logic [ADDR_W-1:0] line_of(logic [ADDR_W-1:0] a);
    return a >> OFFS_W;
  endfunction

  task automatic check(string tag, logic act, logic exp, string what);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, logic [1:0] kind, logic [ADDR_W-1:0] addr,
                      logic inv = 1'b0, logic [ADDR_W-1:0] iaddr = '0);
    logic ok;
    exp_t e;
    op_kind   = kind;
    op_addr   = addr;
    inv_valid = inv;
    inv_addr  = iaddr;
    @(posedge clk);
    ok = (kind == K_SC) && m_valid && (line_of(addr) == m_line) &&
         !(inv && line_of(iaddr) == m_line);
    case (kind)
      K_LL: begin m_valid = 1'b1; m_line = line_of(addr); end
      K_SC: m_valid = 1'b0;
      K_WR: if (m_valid && line_of(addr) == m_line) m_valid = 1'b0;
      default: ;
    endcase
    if (inv && line_of(iaddr) == m_line) m_valid = 1'b0;
    if (kind == K_SC) begin
      e.ok  = ok;
      e.tag = tag;
      expq.push_back(e);
    end
    @(negedge clk);
    op_kind   = K_IDLE;
    inv_valid = 1'b0;
  endtask

  // monitor: pop one expected verdict per sc_valid pulse
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (sc_valid) begin
        if (expq.size() == 0) begin
          check("R6", sc_valid, 1'b0, "unexpected verdict");
        end else begin
          exp_t e;
          e = expq.pop_front();
          check(e.tag, sc_ok, e.ok, "sc_ok_o");
        end
      end else begin
        if (expq.size() != 0) begin
          check("R6", sc_valid, 1'b1, "missing verdict");
          void'(expq.pop_front());
        end
        check("R6", sc_ok, 1'b0, "sc_ok_o while idle");
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", sc_valid, 1'b0, "sc_valid_o in reset");
    check("R1", sc_ok, 1'b0, "sc_ok_o in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", sc_valid, 1'b0, "sc_valid_o after reset");
    step("R1", K_SC, LA);
    // pass across offsets in the line
    step("R2", K_LL, LA);
    step("R9", K_SC, LA2);
    step("R4", K_SC, LA);
    // wrong line fails, still clears
    step("R2", K_LL, LA);
    step("R3", K_SC, LB);
    step("R4", K_SC, LA);
    // writes
    step("R2", K_LL, LA);
    step("R5", K_WR, LB);
    step("R5", K_SC, LA);
    step("R2", K_LL, LA);
    step("R5", K_WR, LA + 8);
    step("R5", K_SC, LA);
    // invalidates alone
    step("R2", K_LL, LA);
    step("R7", K_IDLE, LB, 1'b1, LB);
    step("R7", K_SC, LA);
    step("R2", K_LL, LA);
    step("R7", K_IDLE, LB, 1'b1, LA2);
    step("R7", K_SC, LA);
    // invalidate coinciding with events
    step("R8", K_LL, LA, 1'b1, LA + 4);
    step("R8", K_SC, LA);
    step("R8", K_LL, LA, 1'b1, LB);
    step("R8", K_SC, LA);
    step("R2", K_LL, LA);
    step("R8", K_SC, LA, 1'b1, LA2);
    step("R2", K_LL, LA);
    step("R8", K_SC, LA, 1'b1, LB);
    // single reservation
    step("R10", K_LL, LA);
    step("R10", K_LL, LB);
    step("R10", K_SC, LA);
    step("R10", K_LL, LA);
    step("R10", K_LL, LB);
    step("R10", K_SC, LB);
    // back-to-back SCs and idle with a live reservation
    step("R2", K_LL, LA);
    step("R6", K_SC, LA);
    step("R6", K_SC, LA);
    step("R2", K_LL, LA);
    step("R6", K_IDLE, LA);
    step("R6", K_IDLE, LA);
    step("R6", K_SC, LA);
    repeat (3) @(negedge clk);
    check("R6", logic'(expq.size() == 0), 1'b1, "verdict queue drained");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule